// File: doc/BRIEF.md
# Maskable Prioritized Interrupt Controller

This block collects fifteen interrupt request lines into a single processor interrupt. Each source has a mask bit, a pending bit and, for the external pins, a sense-select bit, all held in 32-bit registers behind a simple synchronous register port. A fourth, read-only register returns the number of the most urgent pending, enabled source, so the interrupt handler can branch on it directly.

Source n occupies register bit 31−n, so source 0 is the most significant bit. Even-numbered sources are external pins whose sense can be level or falling edge. Odd-numbered sources are internal and are always level-sensitive. Every request input passes through a two-stage synchronizer before it is used. An edge-sensitive source latches its pending bit on a falling edge and holds it until software writes a one to that bit. A level-sensitive source's pending bit follows the synchronized input.

The register port is control traffic and uses plain strobes, with no handshake. A write takes effect at the clock edge where `reg_wr_i` is high. A read returns data on `reg_rdata_o` from the clock edge where `reg_rd_i` is high, and the data holds until the next read. The select codes are 0 for mask, 1 for pending, 2 for sense-select and 3 for vector.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source n maps to bit 31−n of the mask, pending and sense-select registers. Bits 16..0 of these registers read as zero.
- R2: `irq_o` is high exactly when at least one source is both pending and has its mask bit set to 1. With the mask all zero, `irq_o` stays low whatever the inputs do.
- R3: Writing 1 to a bit of the pending register (select 1) clears that source's latched edge, and writing 0 leaves it unchanged. If a clear and a new falling edge arrive at the same clock edge, the bit stays set.
- R4: For an even source whose sense-select bit is 1, a falling edge on the synchronized input sets the pending bit. The bit then stays set through later rising edges until it is cleared. A rising edge alone does not set it.
- R5: Sense-select bits of odd (internal) sources cannot be written and read as zero. Odd sources behave as level-sensitive even after all ones are written to select 2.
- R6: With sense-select 0, a source's pending bit follows its input level (active high), delayed by the two synchronizer stages.
- R7: A read of select 3 returns the lowest-numbered source that is pending and unmasked, in bits [31:26], with bits [25:0] zero.
- R8: When no source is both pending and unmasked, a read of select 3 returns 15 in bits [31:26].
- R9: After reset, the mask, pending and sense-select registers read zero, `irq_o` is low, and the vector reads 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 15 | Request inputs, bit n is source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 pending, 2 sense-select, 3 vector |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The hardest case to reach is a write-one-to-clear that lands on the same clock edge as a newly detected falling edge on the same source. The bench lowers the pin at a known falling clock edge. It counts the two synchronizer stages and the edge-detect register, then strobes the clear so that it meets the edge detection exactly, and checks that the pending bit survives. Priority is covered by sweeping every pair of active sources, and the mapping by sweeping every single source under both full and single-bit masks.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    RS_MASK = 2'd0,
    RS_PEND = 2'd1,
    RS_ESEL = 2'd2,
    RS_VEC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_vec_sync.sv
module irq_vec_sync #(
  parameter int N      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_vec_pend.sv
module irq_vec_pend #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] esel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] lat_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d_q <= '0;
    else lvl_d_q <= lvl_i;
  end

  for (genvar n = 0; n < N; n++) begin : g_src
    if (n % 2 == 0) begin : g_ext
      logic lat_q;
      assign fall_o[n] = lvl_d_q[n] & ~lvl_i[n];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= 1'b0;
        else if (!esel_i[n]) lat_q <= 1'b0;
        else lat_q <= (lat_q & ~clr_i[n]) | fall_o[n];
      end
      assign lat_o[n]  = lat_q;
      assign pend_o[n] = esel_i[n] ? lat_q : lvl_i[n];
    end else begin : g_int
      assign fall_o[n] = 1'b0;
      assign lat_o[n]  = 1'b0;
      assign pend_o[n] = lvl_i[n];
    end
  end
endmodule

// File: rtl/irq_vec_prio.sv
module irq_vec_prio #(
  parameter int N    = 15,
  parameter int VW   = 6,
  parameter int SPUR = 15
) (
  input  logic [N-1:0]  act_i,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    vec_o = VW'(SPUR);
    for (int n = N-1; n >= 0; n--) begin
      if (act_i[n]) vec_o = VW'(n);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NSRC   = 15,
  parameter int DW     = 32,
  parameter int VW     = 6,
  parameter int SPUR   = 15,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o
);
  import irq_vec_pkg::*;

  localparam int PADW = DW - VW;

  logic [NSRC-1:0] lvl_w, pend_w, lat_w, fall_w, clr_w, act_w;
  logic [NSRC-1:0] mask_q, esel_q, wd_src_w, esel_d_w;
  logic [DW-1:0]   mask_word_w, pend_word_w, esel_word_w;
  logic [VW-1:0]   vec_w;
  logic            wr_mask_w, wr_pend_w, wr_esel_w;

  assign wr_mask_w = reg_wr_i && (reg_sel_i == RS_MASK);
  assign wr_pend_w = reg_wr_i && (reg_sel_i == RS_PEND);
  assign wr_esel_w = reg_wr_i && (reg_sel_i == RS_ESEL);

  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign wd_src_w[n] = reg_wdata_i[DW-1-n];
    assign esel_d_w[n] = (n % 2 == 0) ? wd_src_w[n] : 1'b0;
  end

  always_comb begin
    mask_word_w = '0;
    pend_word_w = '0;
    esel_word_w = '0;
    for (int n = 0; n < NSRC; n++) begin
      mask_word_w[DW-1-n] = mask_q[n];
      pend_word_w[DW-1-n] = pend_w[n];
      esel_word_w[DW-1-n] = esel_q[n];
    end
  end

  assign clr_w = wr_pend_w ? wd_src_w : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      esel_q <= '0;
    end else begin
      if (wr_mask_w) mask_q <= wd_src_w;
      if (wr_esel_w) esel_q <= esel_d_w;
    end
  end

  irq_vec_sync #(.N(NSRC), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl_w)
  );

  irq_vec_pend #(.N(NSRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .esel_i(esel_q),
    .clr_i(clr_w), .pend_o(pend_w), .lat_o(lat_w), .fall_o(fall_w)
  );

  assign act_w = pend_w & mask_q;

  irq_vec_prio #(.N(NSRC), .VW(VW), .SPUR(SPUR)) prio_i (
    .act_i(act_w), .vec_o(vec_w)
  );

  assign irq_o = |act_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata_o <= '0;
    else if (reg_rd_i) begin
      case (reg_sel_e'(reg_sel_i))
        RS_MASK: reg_rdata_o <= mask_word_w;
        RS_PEND: reg_rdata_o <= pend_word_w;
        RS_ESEL: reg_rdata_o <= esel_word_w;
        default: reg_rdata_o <= {vec_w, {PADW{1'b0}}};
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NSRC = 15,
  parameter int DW   = 32,
  parameter int VW   = 6,
  parameter int SPUR = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_rd_i,
  input logic [1:0]      reg_sel_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            irq_o,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] esel_q,
  input logic [NSRC-1:0] pend_w,
  input logic [NSRC-1:0] lat_w,
  input logic [NSRC-1:0] fall_w,
  input logic [NSRC-1:0] clr_w
);
  p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w != '0) |=> ((lat_w & $past(clr_w) & ~$past(fall_w)) == '0));

  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_w != '0) |=> (($past(lat_w) & $past(esel_q) & ~$past(clr_w) & ~lat_w) == '0));

  p_vec_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i == 2'd3 && (pend_w & mask_q) == '0)
    |=> (reg_rdata_o == {VW'(SPUR), {(DW-VW){1'b0}}}));

  p_vec_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i == 2'd3 && (pend_w & mask_q) != '0)
    |=> (int'(reg_rdata_o[DW-1 -: VW]) < NSRC));

  p_odd_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esel_q[1]) |-> 1'b0);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NSRC(NSRC), .DW(DW), .VW(VW), .SPUR(SPUR)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd_i(reg_rd_i), .reg_sel_i(reg_sel_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .mask_q(mask_q), .esel_q(esel_q),
  .pend_w(pend_w), .lat_w(lat_w), .fall_w(fall_w), .clr_w(clr_w)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  localparam int N = 15;
  localparam logic [31:0] MASK_ALL = 32'hFFFE_0000;
  localparam logic [31:0] SPUR_W   = 32'd15 << 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] bitw(int n);
    return 32'h1 << (31 - n);
  endfunction

  function automatic logic [31:0] vecw(int n);
    return 32'(n) << 26;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; sel = s;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin : main
    logic [31:0] d, ext;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R9 reset state
    rreg(2'd0, d); chk("R9 mask", d, 32'h0);
    rreg(2'd1, d); chk("R9 pend", d, 32'h0);
    rreg(2'd2, d); chk("R9 esel", d, 32'h0);
    rreg(2'd3, d); chk("R9 vec", d, SPUR_W);
    chk("R9 irq", {31'h0, irq}, 32'h0);

    // R1 unused mask bits read zero
    wreg(2'd0, 32'hFFFF_FFFF);
    rreg(2'd0, d); chk("R1 mask bits", d, MASK_ALL);

    // R5 internal sense bits not writable
    ext = '0;
    for (int n = 0; n < N; n += 2) ext |= bitw(n);
    wreg(2'd2, 32'hFFFF_FFFF);
    rreg(2'd2, d); chk("R5 esel readback", d, ext);
    for (int n = 1; n < N; n += 2) begin
      src[n] = 1'b1; wait_n(3);
      rreg(2'd1, d); chk("R5 odd level high", d, bitw(n));
      src[n] = 1'b0; wait_n(3);
      rreg(2'd1, d); chk("R5 odd level low", d, 32'h0);
    end
    wreg(2'd2, 32'h0);

    // R6 R1 R7 R2 single-source level sweep, full mask
    for (int n = 0; n < N; n++) begin
      src = '0; src[n] = 1'b1; wait_n(3);
      rreg(2'd1, d); chk("R6 R1 pend", d, bitw(n));
      rreg(2'd3, d); chk("R7 vec single", d, vecw(n));
      chk("R2 irq on", {31'h0, irq}, 32'h1);
    end
    src = '0; wait_n(3);
    chk("R2 irq off", {31'h0, irq}, 32'h0);

    // R7 R8 R2 single-bit mask sweep with all sources high
    src = '1; wait_n(3);
    for (int n = 0; n < N; n++) begin
      wreg(2'd0, bitw(n));
      rreg(2'd3, d); chk("R7 masked vec", d, vecw(n));
      chk("R2 single mask irq", {31'h0, irq}, 32'h1);
    end
    wreg(2'd0, 32'h0);
    rreg(2'd3, d); chk("R8 spurious", d, SPUR_W);
    chk("R2 zero mask", {31'h0, irq}, 32'h0);

    // R7 priority over every pair
    wreg(2'd0, MASK_ALL);
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        src = '0; src[i] = 1'b1; src[j] = 1'b1; wait_n(3);
        rreg(2'd3, d); chk("R7 pair", d, vecw(i));
      end
    end
    src = '0; wait_n(3);
    rreg(2'd3, d); chk("R8 empty", d, SPUR_W);

    // R4 R3 edge behaviour per external source
    for (int n = 0; n < N; n += 2) begin
      src[n] = 1'b1; wait_n(4);
      wreg(2'd2, bitw(n));
      rreg(2'd1, d); chk("R4 no set on high", d, 32'h0);
      src[n] = 1'b0; wait_n(4);
      rreg(2'd1, d); chk("R4 falling latch", d, bitw(n));
      chk("R2 edge irq", {31'h0, irq}, 32'h1);
      src[n] = 1'b1; wait_n(4);
      rreg(2'd1, d); chk("R4 held over rise", d, bitw(n));
      wreg(2'd1, ~bitw(n));
      rreg(2'd1, d); chk("R3 zero write no effect", d, bitw(n));
      wreg(2'd1, bitw(n));
      rreg(2'd1, d); chk("R3 w1c clears", d, 32'h0);
      // R3 clear meeting a new edge on the same clock edge
      @(negedge clk); src[n] = 1'b0;
      @(negedge clk);
      @(negedge clk); wr = 1'b1; sel = 2'd1; wdata = bitw(n);
      @(negedge clk); wr = 1'b0;
      rreg(2'd1, d); chk("R3 edge wins over clear", d, bitw(n));
      wreg(2'd2, 32'h0);
      wait_n(1);
      src[n] = 1'b0; wait_n(3);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule